// File: doc/BRIEF.md
# Bus Command Controller

This block sits beside a processor that announces each bus cycle on three status lines. It watches those lines on the processor clock and expands the code into separate, timed strobes. These are memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also drives early ("advanced") write strobes for memory and I/O, an address latch pulse, and the enable and direction lines for an external data transceiver. Address latches and transceivers themselves live outside the block.

A cycle begins when the status lines leave the idle (passive) code. The first clock of the cycle carries the address latch pulse. From the second clock, the read strobe or advanced write strobe for the cycle's type is held until the status returns to passive. The normal write strobe follows its advanced form by a parameterised number of clocks. Three inputs gate the commands. One enables commands as a whole. One gives the address side access to the bus. The third selects a mode that serves a dedicated I/O bus only.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: Status codes are INTA=000, IORD=001, IOWR=010, HALT=011, FETCH=100, MEMRD=101, MEMWR=110 and PASSIVE=111. A cycle starts at the first rising edge that samples a non-passive code while idle. `ale` is high for exactly the clock that follows that edge.
- R2: At most one of `mem_rd`, `mem_wr`, `io_rd` and `io_wr` is high at any time.
- R3: Read-type commands go high from the second clock of the cycle. FETCH and MEMRD drive `mem_rd`, IORD drives `io_rd` and INTA drives `int_ack`. They fall right after the edge that samples PASSIVE.
- R4: Advanced writes (`adv_mem_wr` for MEMWR, `adv_io_wr` for IOWR) go high from the second clock. The normal write goes high WR_LAG clocks later (default 1, so from the third clock). Both stay high until the cycle ends.
- R5: A different non-passive code that appears during a cycle, with no passive code between, has no effect. The cycle keeps its first type.
- R6: A HALT cycle drives no command strobe and no `data_en`, although `ale` still pulses.
- R7: `data_en` is high from the second clock to the end of every non-halt cycle. `data_dir` is high (transmit) for the whole of MEMWR and IOWR cycles and low otherwise.
- R8: With `cmd_enable` low, all seven command outputs are low. `ale`, `data_en` and `data_dir` are unaffected.
- R9: With `addr_enable` low, the memory commands are low. The I/O commands and `int_ack` are also low unless `io_only` is high, in which case they follow `cmd_enable` alone.
- R10: With `io_only` high, `mem_rd`, `mem_wr` and `adv_mem_wr` stay low.
- R11: Reset is synchronous and active low. After a reset edge the block is idle and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_status | input | 3 | Bus cycle type code from the processor |
| addr_enable | input | 1 | High when the address side may drive commands |
| cmd_enable | input | 1 | High to allow command outputs |
| io_only | input | 1 | High to serve only a dedicated I/O bus |
| ale | output | 1 | Address latch pulse, first clock of a cycle |
| data_en | output | 1 | Transceiver enable |
| data_dir | output | 1 | Transceiver direction, 1 = transmit (write) |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| adv_mem_wr | output | 1 | Early memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| adv_io_wr | output | 1 | Early I/O write command |
| int_ack | output | 1 | Interrupt acknowledge command |

## Verification
The assertions assume that `cyc_status` changes only between clock edges and that a cycle type, once sampled, is the one the strobes belong to. Mid-cycle code changes are therefore legal input, and the assertions only check that the latched type stays stable. The random stimulus holds each status for random runs of clocks and returns to passive often. Now and then it injects a foreign code inside a cycle, and it toggles the three gating inputs at any clock. Directed sequences cover halt, interrupt acknowledge, I/O-only mode without address access, disabled commands and reset in the middle of a cycle.

// File: rtl/bcc_pkg.sv
`timescale 1ns/1ps
// Shared types for the bus command controller.
// Assumes a 3-bit status code; the code values below set the decode.
package bcc_pkg;
    typedef enum logic [2:0] {
        CYC_INTA    = 3'b000,
        CYC_IORD    = 3'b001,
        CYC_IOWR    = 3'b010,
        CYC_HALT    = 3'b011,
        CYC_FETCH   = 3'b100,
        CYC_MEMRD   = 3'b101,
        CYC_MEMWR   = 3'b110,
        CYC_PASSIVE = 3'b111
    } cyc_code_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2
    } phase_e;
endpackage

// File: rtl/bcc_phase_tracker.sv
`timescale 1ns/1ps
// Tracks the phase of the current bus cycle from the status lines.
// Starts a cycle on a non-passive code while idle and latches its type.
// Ends it when passive is sampled. Codes seen mid-cycle are ignored.
// Assumes status is stable around the rising clock edge.
module bcc_phase_tracker #(
    parameter int WR_LAG = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cyc_status,
    output logic                phase_addr,
    output logic                phase_cmd,
    output logic                phase_late,
    output bcc_pkg::cyc_code_e  cyc_type
);
    import bcc_pkg::*;

    phase_e    state_q;
    cyc_code_e type_q;
    logic      passive_now;

    assign passive_now = (cyc_status == CYC_PASSIVE);

    // Phase state machine and cycle type latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            type_q  <= CYC_PASSIVE;
        end else begin
            case (state_q)
                PH_IDLE: if (!passive_now) begin
                    state_q <= PH_ADDR;
                    type_q  <= cyc_code_e'(cyc_status);
                end
                PH_ADDR: state_q <= passive_now ? PH_IDLE : PH_CMD;
                PH_CMD:  if (passive_now) state_q <= PH_IDLE;
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_addr = (state_q == PH_ADDR);
    assign phase_cmd  = (state_q == PH_CMD);
    assign cyc_type   = type_q;

    generate
        if (WR_LAG == 0) begin : g_no_lag
            assign phase_late = phase_cmd;
        end else begin : g_lag
            localparam int        CW      = $clog2(WR_LAG + 1);
            localparam logic [CW-1:0] LAG_MAX = CW'(WR_LAG);
            logic [CW-1:0] lag_q;

            // Counts command-phase clocks up to the write lag
            always_ff @(posedge clk) begin
                if (!rst_n)                lag_q <= '0;
                else if (!phase_cmd)       lag_q <= '0;
                else if (lag_q != LAG_MAX) lag_q <= lag_q + 1'b1;
            end

            assign phase_late = phase_cmd && (lag_q == LAG_MAX);

            // R4
            late_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(phase_late) |-> $past(phase_cmd));
        end
    endgenerate

    // R1
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_addr |=> !phase_addr);

    // R3
    cmd_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_cmd) |-> $past(phase_addr));

    // R5
    type_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_cmd |-> $stable(cyc_type));
endmodule

// File: rtl/bcc_cmd_decode.sv
`timescale 1ns/1ps
// Turns the phase and the latched cycle type into the seven command strobes.
// Applies command enable, address enable and I/O-only gating.
// Assumes the phase inputs come from bcc_phase_tracker.
module bcc_cmd_decode (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_cmd,
    input  logic               phase_late,
    input  bcc_pkg::cyc_code_e cyc_type,
    input  logic               addr_enable,
    input  logic               cmd_enable,
    input  logic               io_only,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               adv_mem_wr,
    output logic               io_rd,
    output logic               io_wr,
    output logic               adv_io_wr,
    output logic               int_ack
);
    import bcc_pkg::*;

    logic mem_ok, io_ok;

    // Gate terms for the memory and I/O command groups
    always_comb begin
        mem_ok = cmd_enable && addr_enable && !io_only;
        io_ok  = cmd_enable && (addr_enable || io_only);
    end

    // Type decode, qualified by phase and gating
    always_comb begin
        mem_rd     = phase_cmd  && mem_ok && (cyc_type == CYC_FETCH || cyc_type == CYC_MEMRD);
        adv_mem_wr = phase_cmd  && mem_ok && (cyc_type == CYC_MEMWR);
        mem_wr     = phase_late && mem_ok && (cyc_type == CYC_MEMWR);
        io_rd      = phase_cmd  && io_ok  && (cyc_type == CYC_IORD);
        adv_io_wr  = phase_cmd  && io_ok  && (cyc_type == CYC_IOWR);
        io_wr      = phase_late && io_ok  && (cyc_type == CYC_IOWR);
        int_ack    = phase_cmd  && io_ok  && (cyc_type == CYC_INTA);
    end

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_HALT) |-> !(mem_rd || mem_wr || adv_mem_wr || io_rd
                                      || io_wr || adv_io_wr || int_ack));

    // R4
    adv_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr |-> adv_mem_wr) and (io_wr |-> adv_io_wr));

    // R10
    io_only_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_only |-> !(mem_rd || mem_wr || adv_mem_wr));

    // R8
    cmd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_enable |-> !(mem_rd || mem_wr || adv_mem_wr || io_rd
                          || io_wr || adv_io_wr || int_ack));
endmodule

// File: rtl/bcc_buffer_ctrl.sv
`timescale 1ns/1ps
// Drives the address latch pulse and the transceiver enable and direction.
// Assumes phase and type come from bcc_phase_tracker. Not gated by enables.
module bcc_buffer_ctrl (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_addr,
    input  logic               phase_cmd,
    input  bcc_pkg::cyc_code_e cyc_type,
    output logic               ale,
    output logic               data_en,
    output logic               data_dir
);
    import bcc_pkg::*;

    logic is_write;

    // Buffer control outputs from phase and type
    always_comb begin
        is_write = (cyc_type == CYC_MEMWR) || (cyc_type == CYC_IOWR);
        ale      = phase_addr;
        data_en  = phase_cmd && (cyc_type != CYC_HALT);
        data_dir = (phase_addr || phase_cmd) && is_write;
    end

    // R7
    dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && !is_write) |-> !data_dir);

    // R7
    en_not_with_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !data_en);
endmodule

// File: rtl/bus_cmd_ctrl.sv
`timescale 1ns/1ps
// Bus command controller top: status-code expansion into timed strobes.
// Assumes cyc_status, enables and mode are synchronous to clk.
module bus_cmd_ctrl #(
    parameter int WR_LAG = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cyc_status,
    input  logic       addr_enable,
    input  logic       cmd_enable,
    input  logic       io_only,
    output logic       ale,
    output logic       data_en,
    output logic       data_dir,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       adv_mem_wr,
    output logic       io_rd,
    output logic       io_wr,
    output logic       adv_io_wr,
    output logic       int_ack
);
    import bcc_pkg::*;

    logic      phase_addr, phase_cmd, phase_late;
    cyc_code_e cyc_type;

    bcc_phase_tracker #(.WR_LAG(WR_LAG)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_status (cyc_status),
        .phase_addr (phase_addr),
        .phase_cmd  (phase_cmd),
        .phase_late (phase_late),
        .cyc_type   (cyc_type)
    );

    bcc_cmd_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_cmd   (phase_cmd),
        .phase_late  (phase_late),
        .cyc_type    (cyc_type),
        .addr_enable (addr_enable),
        .cmd_enable  (cmd_enable),
        .io_only     (io_only),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .adv_mem_wr  (adv_mem_wr),
        .io_rd       (io_rd),
        .io_wr       (io_wr),
        .adv_io_wr   (adv_io_wr),
        .int_ack     (int_ack)
    );

    bcc_buffer_ctrl u_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_addr (phase_addr),
        .phase_cmd  (phase_cmd),
        .cyc_type   (cyc_type),
        .ale        (ale),
        .data_en    (data_en),
        .data_dir   (data_dir)
    );

    // R2
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1);

    // R1
    ale_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !(mem_rd || io_rd || int_ack || adv_mem_wr || adv_io_wr));
endmodule

// File: tb/bus_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_cmd_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] st = 3'b111;
    logic       ae = 1'b1, ce = 1'b1, iob = 1'b0;
    logic ale, data_en, data_dir, mem_rd, mem_wr, adv_mem_wr, io_rd, io_wr, adv_io_wr, int_ack;

    int errs = 0, checks = 0, cycles = 0;
    bit chk_on = 0;
    string cur_req = "R11 reset";

    // reference model state
    bit       m_busy = 0;
    int       m_idx = 0;
    logic [2:0] m_type = 3'b111;

    always #10 clk = ~clk;

    bus_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_status(st), .addr_enable(ae),
        .cmd_enable(ce), .io_only(iob), .ale(ale), .data_en(data_en),
        .data_dir(data_dir), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .adv_mem_wr(adv_mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .adv_io_wr(adv_io_wr), .int_ack(int_ack)
    );

    // Reference model updated on the sampling edge
    always @(posedge clk) begin
        cycles++;
        chk_on = 1;
        if (!rst_n) m_busy = 0;
        else if (!m_busy) begin
            if (st != 3'b111) begin m_busy = 1; m_idx = 0; m_type = st; end
        end else if (st == 3'b111) m_busy = 0;
        else if (m_idx < 3) m_idx++;
        if (cycles > 150000) begin
            errs++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s [%s] t=%0t actual=%b expected=%b", tag, cur_req, $time, act, exp);
        end
    endtask

    // Compare outputs with the model, away from the active edge
    always @(negedge clk) if (chk_on) begin
        bit cmd, late, mok, iok;
        logic [7:0] e_rd, e_wr, e_buf;
        cmd  = m_busy && m_idx >= 1;
        late = m_busy && m_idx >= 2;
        mok  = ce && ae && !iob;
        iok  = ce && (ae || iob);
        e_rd  = {5'b0, cmd && mok && (m_type == 3'd4 || m_type == 3'd5),
                 cmd && iok && m_type == 3'd1, cmd && iok && m_type == 3'd0};
        e_wr  = {4'b0, cmd && mok && m_type == 3'd6, late && mok && m_type == 3'd6,
                 cmd && iok && m_type == 3'd2, late && iok && m_type == 3'd2};
        e_buf = {6'b0, cmd && m_type != 3'd3, m_busy && (m_type == 3'd2 || m_type == 3'd6)};
        chk("R1 ale", {7'b0, ale}, {7'b0, m_busy && m_idx == 0});
        chk("R3 reads", {5'b0, mem_rd, io_rd, int_ack}, e_rd);
        chk("R4 writes", {4'b0, adv_mem_wr, mem_wr, adv_io_wr, io_wr}, e_wr);
        chk("R7 buffers", {6'b0, data_en, data_dir}, e_buf);
        chk("R2 exclusive", {7'b0, $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1}, 8'd1);
    end

    task automatic drive(input logic [2:0] s, input logic a, input logic c, input logic b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
            st = s; ae = a; ce = c; iob = b;
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        cur_req = "R11 reset";
        drive(3'b111, 1, 1, 0, 3);
        @(negedge clk); #2 rst_n = 1'b1;
        cur_req = "R4 memory write";   drive(3'b110, 1, 1, 0, 4); drive(3'b111, 1, 1, 0, 2);
        cur_req = "R3 io read";        drive(3'b001, 1, 1, 0, 3); drive(3'b111, 1, 1, 0, 2);
        cur_req = "R3 fetch";          drive(3'b100, 1, 1, 0, 3); drive(3'b111, 1, 1, 0, 2);
        cur_req = "R6 halt";           drive(3'b011, 1, 1, 0, 4); drive(3'b111, 1, 1, 0, 2);
        cur_req = "R3 int ack";        drive(3'b000, 1, 1, 0, 3); drive(3'b111, 1, 1, 0, 2);
        cur_req = "R9 io only no addr";drive(3'b010, 0, 1, 1, 4); drive(3'b111, 0, 1, 1, 2);
        cur_req = "R10 io only mem";   drive(3'b110, 1, 1, 1, 4); drive(3'b111, 1, 1, 0, 2);
        cur_req = "R9 no addr";        drive(3'b101, 0, 1, 0, 3); drive(3'b111, 1, 1, 0, 2);
        cur_req = "R8 cmd off";        drive(3'b010, 1, 0, 0, 4); drive(3'b111, 1, 1, 0, 2);
        cur_req = "R5 code change";    drive(3'b101, 1, 1, 0, 2); drive(3'b010, 1, 1, 0, 3);
                                       drive(3'b111, 1, 1, 0, 2);
        cur_req = "R1 short cycle";    drive(3'b001, 1, 1, 0, 1); drive(3'b111, 1, 1, 0, 2);
        cur_req = "R11 reset mid-cycle"; drive(3'b110, 1, 1, 0, 3);
        @(negedge clk); #2 rst_n = 1'b0;
        drive(3'b111, 1, 1, 0, 2);
        @(negedge clk); #2 rst_n = 1'b1;
        cur_req = "R2 random";
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] s;
            int r;
            r = $urandom;
            s = st;
            if (st == 3'b111) begin
                if (r % 2 == 0) s = 3'($urandom % 7);
            end else if (r % 4 == 0) s = 3'b111;
            else if (r % 16 == 1) s = 3'($urandom % 7);
            drive(s, ($urandom % 8 == 0) ? ~ae : ae, ($urandom % 8 == 0) ? ~ce : ce,
                  ($urandom % 8 == 0) ? ~iob : iob, 1);
        end
        drive(3'b111, 1, 1, 0, 3);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule